// File: doc/BRIEF.md
# Keyboard Controller Clock Enable Generator

This block produces the clock-enable strobe that paces an embedded keyboard controller. All logic runs on one core clock; the two candidate timing sources arrive as single-cycle strobes. `xtal_tick` marks each edge of the crystal-derived clock, and `sys_tick` marks each edge of the system clock. With the crystal source chosen, the block divides the crystal strobes by two or by three. With the system source chosen, every system strobe is passed on unchanged. In that mode the keyboard controller keeps running through power-down, when the crystal strobes stop.

Four control inputs steer the block: a run enable, a speed choice, a source choice and an arming bit that must be 1. The block produces strobes only when both the enable and the arming bit are 1. At any other time the output stays low and the frozen flag is raised. The source choice is sampled only while the block is stopped. A change made while running is therefore held back, so the output never switches between sources partway through a division period.

Top module: `kbclk_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, `kbc_ce` is 0 and `kbc_frozen` is 1 after that edge. The held source returns to crystal (0), the divider count returns to 0 and the held speed returns to 0.
- R2: With the crystal source held (0), `ctl_speed` = 0 and the block running, `kbc_ce` is 1 in the cycle after every third accepted `xtal_tick`. Counting starts afresh each time the block starts running.
- R3: With the crystal source held and `ctl_speed` = 1, `kbc_ce` is 1 in the cycle after every second accepted `xtal_tick`.
- R4: With the system source held (1) and the block running, `kbc_ce` in each cycle equals `sys_tick` of the previous cycle. `ctl_speed` and its changes have no effect in this mode.
- R5: When `ctl_enable` is 0 at an edge, `kbc_ce` is 0 and `kbc_frozen` is 1 after that edge.
- R6: When `ctl_arm` is 0 at an edge, `kbc_ce` is 0 and `kbc_frozen` is 1 after that edge, whatever `ctl_enable` is.
- R7: `ctl_src_sys` (1 = system, 0 = crystal) is captured at every edge where the block is not running and is held while it runs. A change made while running has no effect until the block has been stopped.
- R8: In crystal mode, an edge where `ctl_speed` differs from its value at the previous edge restarts the count. The `xtal_tick` at that edge is discarded, and the next strobe follows N accepted ticks later.
- R9: `kbc_frozen` is 0 exactly in the cycles after an edge at which the block was running. `kbc_ce` and `kbc_frozen` are never both 1.
- R10: Only the held source's strobes count. `sys_tick` has no effect in crystal mode, and `xtal_tick` has no effect in system mode, including on the divider's count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xtal_tick | input | 1 | One-cycle strobe per crystal clock edge |
| sys_tick | input | 1 | One-cycle strobe per system clock edge |
| ctl_enable | input | 1 | Run enable, 1 = run |
| ctl_speed | input | 1 | Crystal ratio: 0 = divide by 3, 1 = divide by 2 |
| ctl_src_sys | input | 1 | Source choice: 0 = crystal, 1 = system |
| ctl_arm | input | 1 | Arming bit, must be 1 for the block to run |
| kbc_ce | output | 1 | Clock-enable strobe for the keyboard controller |
| kbc_frozen | output | 1 | 1 while no strobes are being produced |

## Verification
A speed change and a due divider strobe can fall in the same cycle. So can a source change and a stop of the block. The bench provokes both overlaps in a long pseudo-random sweep, where enable, arming, speed and source flip at random moments against dense and sparse tick patterns. It also provokes them in directed phases that time each flip onto the tick that would have completed a period. A bench model, built from the requirements, predicts every cycle's outputs with a tick count and a held source. Each overlap is judged by whether the strobe is dropped and the count restarted, or the new source is delayed until the stop.

// File: rtl/kbclk_pkg.sv
// Package for the keyboard clock enable generator.
// Holds the source encoding and the default ratios shared by the modules.
package kbclk_pkg;

    // Source choice as held inside the block: 0 crystal, 1 system.
    typedef enum logic {
        SRC_XTAL = 1'b0,
        SRC_SYS  = 1'b1
    } kbclk_src_e;

    // Default crystal ratios.
    localparam int unsigned DIV_SLOW_DEF = 3;
    localparam int unsigned DIV_FAST_DEF = 2;

endpackage

// File: rtl/kbclk_run_ctl.sv
// Run control and source hold.
// Does:    Combines the enable and arming bits into a run condition and holds
//          the source choice. The choice is sampled only while stopped.
// Assumes: Control inputs are synchronous to clk.
module kbclk_run_ctl
    import kbclk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_enable,
    input  logic       ctl_arm,
    input  logic       ctl_src_sys,
    output logic       run,
    output kbclk_src_e src_q
);

    // Running only when both the enable and the arming bit are set.
    always_comb begin
        run = ctl_enable & ctl_arm;
    end

    // Capture the source choice while stopped; hold it while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= SRC_XTAL;
        end else if (!run) begin
            src_q <= ctl_src_sys ? SRC_SYS : SRC_XTAL;
        end
    end

    // R7
    src_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> $stable(src_q));

endmodule

// File: rtl/kbclk_divider.sv
// Crystal strobe divider.
// Does:    Counts accepted crystal strobes and flags the one that ends a
//          period of DIV_FAST or DIV_SLOW strobes. A change of speed, or a
//          stop, clears the count.
// Assumes: Both ratios are 2 or more. count_en is 0 in system mode.
module kbclk_divider #(
    parameter int unsigned DIV_SLOW = 3,
    parameter int unsigned DIV_FAST = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic count_en,
    input  logic speed,
    input  logic xtal_tick,
    output logic hit
);

    localparam int unsigned MAX_DIV = (DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST;
    localparam int unsigned CNT_W   = (MAX_DIV > 2) ? $clog2(MAX_DIV) : 1;
    localparam logic [CNT_W-1:0] LAST_SLOW = CNT_W'(DIV_SLOW - 1);
    localparam logic [CNT_W-1:0] LAST_FAST = CNT_W'(DIV_FAST - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last;
    logic             speed_q;
    logic             restart;
    logic             accept;

    // Final count of the period for the present speed.
    always_comb begin
        last = speed ? LAST_FAST : LAST_SLOW;
    end

    // Restart when the speed differs from the previous edge; accept ticks otherwise.
    always_comb begin
        restart = (speed != speed_q);
        accept  = run & count_en & xtal_tick & ~restart;
        hit     = accept & (cnt_q == last);
    end

    // Remember the speed seen at each edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            speed_q <= 1'b0;
        end else begin
            speed_q <= speed;
        end
    end

    // Advance the count on accepted ticks, clear on stop or restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || restart) begin
            cnt_q <= '0;
        end else if (accept) begin
            cnt_q <= hit ? '0 : cnt_q + 1'b1;
        end
    end

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (speed == speed_q) |-> (cnt_q <= last));

    // R3
    fast_no_b2b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (speed && hit) |=> !hit);

    // R8
    restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (speed != speed_q) |=> (cnt_q == '0));

endmodule

// File: rtl/kbclk_out_stage.sv
// Output stage.
// Does:    Picks the strobe of the held source and registers the
//          clock-enable and frozen outputs.
// Assumes: hit is already 0 unless the crystal source is held and running.
module kbclk_out_stage
    import kbclk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  kbclk_src_e src_q,
    input  logic       hit,
    input  logic       sys_tick,
    output logic       kbc_ce,
    output logic       kbc_frozen
);

    logic ce_d;

    // Select the strobe of the held source, gated by the run condition.
    always_comb begin
        ce_d = run & ((src_q == SRC_SYS) ? sys_tick : hit);
    end

    // Register the strobe and the frozen flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kbc_ce     <= 1'b0;
            kbc_frozen <= 1'b1;
        end else begin
            kbc_ce     <= ce_d;
            kbc_frozen <= ~run;
        end
    end

    // R4
    sys_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && src_q == SRC_SYS) |=> (kbc_ce == $past(sys_tick)));

    // R9
    ce_frozen_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(kbc_ce && kbc_frozen));

endmodule

// File: rtl/kbclk_gen.sv
// Keyboard controller clock enable generator, top level.
// Does:    Produces a clock-enable strobe from the crystal strobes, divided
//          by DIV_SLOW or DIV_FAST, or from the system strobes unchanged.
//          Raises a frozen flag while stopped.
// Assumes: Both tick inputs are one-cycle strobes synchronous to clk.
module kbclk_gen
    import kbclk_pkg::*;
#(
    parameter int unsigned DIV_SLOW = DIV_SLOW_DEF,
    parameter int unsigned DIV_FAST = DIV_FAST_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic xtal_tick,
    input  logic sys_tick,
    input  logic ctl_enable,
    input  logic ctl_speed,
    input  logic ctl_src_sys,
    input  logic ctl_arm,
    output logic kbc_ce,
    output logic kbc_frozen
);

    logic       run;
    kbclk_src_e src_q;
    logic       xtal_sel;
    logic       hit;

    // Let the divider count only while the crystal source is held.
    always_comb begin
        xtal_sel = (src_q == SRC_XTAL);
    end

    kbclk_run_ctl u_run_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctl_enable  (ctl_enable),
        .ctl_arm     (ctl_arm),
        .ctl_src_sys (ctl_src_sys),
        .run         (run),
        .src_q       (src_q)
    );

    kbclk_divider #(
        .DIV_SLOW (DIV_SLOW),
        .DIV_FAST (DIV_FAST)
    ) u_divider (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .count_en  (xtal_sel),
        .speed     (ctl_speed),
        .xtal_tick (xtal_tick),
        .hit       (hit)
    );

    kbclk_out_stage u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .src_q      (src_q),
        .hit        (hit),
        .sys_tick   (sys_tick),
        .kbc_ce     (kbc_ce),
        .kbc_frozen (kbc_frozen)
    );

    // R5
    stop_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_enable |=> (!kbc_ce && kbc_frozen));

    // R6
    arm_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_arm |=> (!kbc_ce && kbc_frozen));

endmodule

// File: tb/tb_kbclk_gen.sv
module tb_kbclk_gen;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic xtal_tick = 1'b0, sys_tick = 1'b0;
    logic ctl_enable = 1'b0, ctl_speed = 1'b0, ctl_src_sys = 1'b0, ctl_arm = 1'b0;
    logic kbc_ce, kbc_frozen;

    int checks = 0;
    int fails  = 0;
    string cur_tag = "";

    // Model state derived from the requirements.
    int   m_cnt = 0;
    logic m_src = 1'b0;
    logic m_spd = 1'b0;
    logic exp_ce = 1'b0;
    logic exp_fz = 1'b1;
    string exp_tag = "R1";
    logic [15:0] lfsr = 16'hACE1;

    always #5 clk = ~clk;

    kbclk_gen dut (
        .clk(clk), .rst_n(rst_n), .xtal_tick(xtal_tick), .sys_tick(sys_tick),
        .ctl_enable(ctl_enable), .ctl_speed(ctl_speed), .ctl_src_sys(ctl_src_sys),
        .ctl_arm(ctl_arm), .kbc_ce(kbc_ce), .kbc_frozen(kbc_frozen)
    );

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not end, actual hung expected done");
        finish_run();
    end

    // One cycle: drive at negedge, predict, compare after the edge.
    task automatic step(input logic en, input logic arm, input logic spd,
                        input logic src, input logic xt, input logic st);
        int  n;
        logic run, restart, hit;
        @(negedge clk);
        ctl_enable = en; ctl_arm = arm; ctl_speed = spd;
        ctl_src_sys = src; xtal_tick = xt; sys_tick = st;
        run = en & arm;
        restart = (spd != m_spd);
        n = spd ? 2 : 3;
        if (!rst_n) begin
            exp_ce = 1'b0; exp_fz = 1'b1; m_cnt = 0; m_src = 1'b0; m_spd = 1'b0;
            exp_tag = "R1";
        end else begin
            hit = !m_src && xt && !restart && (m_cnt == n - 1);
            exp_ce = run & (m_src ? st : hit);
            exp_fz = !run;
            if (!en)           exp_tag = "R5";
            else if (!arm)     exp_tag = "R6";
            else if (m_src)    exp_tag = "R4";
            else if (restart)  exp_tag = "R8";
            else if (spd)      exp_tag = "R3";
            else               exp_tag = "R2";
            if (cur_tag != "") exp_tag = cur_tag;
            if (!run || restart) m_cnt = 0;
            else if (xt && !m_src) m_cnt = (m_cnt == n - 1) ? 0 : m_cnt + 1;
            if (!run) m_src = src;
            m_spd = spd;
        end
        @(posedge clk);
        #1;
        checks++;
        if (kbc_ce !== exp_ce) begin
            fails++;
            $display("FAIL %s kbc_ce: actual %b expected %b at %0t", exp_tag, kbc_ce, exp_ce, $time);
        end
        checks++;
        if (kbc_frozen !== exp_fz) begin
            fails++;
            $display("FAIL R9 (%s) kbc_frozen: actual %b expected %b at %0t", exp_tag, kbc_frozen, exp_fz, $time);
        end
    endtask

    task automatic lfsr_next();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endtask

    initial begin
        logic en, arm, spd, src, xt, st;
        // R1: reset state
        cur_tag = "R1";
        for (int i = 0; i < 3; i++) step(1, 1, 1, 1, 1, 1);
        @(negedge clk); rst_n = 1'b1;
        cur_tag = "";
        // Stop, then sweep source, speed and tick density, crystal and system.
        for (int s = 0; s < 2; s++)
            for (int p = 0; p < 2; p++)
                for (int d = 1; d <= 3; d++) begin
                    step(0, 1, p[0], s[0], 0, 0);
                    step(0, 1, p[0], s[0], 0, 0);
                    for (int c = 0; c < 24; c++)
                        step(1, 1, p[0], s[0], (c % d) == 0, (c % (d + 1)) == 0);
                end
        // R10: foreign strobes in each mode.
        cur_tag = "R10";
        step(0, 1, 0, 0, 0, 0);
        for (int c = 0; c < 20; c++) step(1, 1, 0, 0, c[0], 1);
        step(0, 1, 0, 1, 0, 0);
        for (int c = 0; c < 20; c++) step(1, 1, 0, 1, 1, c[1]);
        // R7: source change while running is held back.
        cur_tag = "R7";
        step(0, 1, 1, 0, 0, 0);
        for (int c = 0; c < 12; c++) step(1, 1, 1, 1, c[0], 1);
        step(0, 1, 1, 1, 0, 0);
        for (int c = 0; c < 6; c++) step(1, 1, 1, 0, 1, c[0]);
        // R8: speed flips on the tick that ends a period.
        cur_tag = "R8";
        step(0, 1, 0, 0, 0, 0);
        for (int k = 0; k < 6; k++) begin
            for (int c = 0; c < 2 + k % 3; c++) step(1, 1, k[0], 0, 1, 0);
            step(1, 1, ~k[0], 0, 1, 0);
        end
        // R6 and R5: arming bit and enable low.
        cur_tag = "R6";
        for (int c = 0; c < 8; c++) step(1, 0, 0, c[2], 1, 1);
        cur_tag = "R5";
        for (int c = 0; c < 8; c++) step(0, 1, 1, c[2], 1, 1);
        // Pseudo-random sweep with the model choosing the tag.
        cur_tag = "";
        en = 1; arm = 1; spd = 0; src = 0;
        for (int c = 0; c < 6000; c++) begin
            lfsr_next();
            if (lfsr[4:0] == 5'd3) en = ~en;
            if (lfsr[9:5] == 5'd7) arm = ~arm;
            if (lfsr[3:0] == 4'd9) spd = ~spd;
            if (lfsr[7:4] == 4'd2) src = ~src;
            xt = lfsr[11] ? 1'b1 : lfsr[12];
            st = lfsr[14];
            step(en, arm, spd, src, xt, st);
        end
        // R1 again: reset in mid-run.
        cur_tag = "R1";
        @(negedge clk); rst_n = 1'b0;
        step(1, 1, 1, 1, 1, 1);
        step(1, 1, 1, 1, 1, 1);
        finish_run();
    end

endmodule